// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

A watchdog timer held in a single 32-bit control word. The word carries a 9-bit timeout count in bits [8:0], a run command in bit 8 (shared with the top bit of the count) and a 7-bit key in bits [15:9]. While the stored run bit is set, software may rewrite the word only by presenting the bitwise inverse of the key held so far. Any other write is dropped without trace. While the stored run bit is clear, any key is taken, and this is how the first key gets in.

The counter steps down once per prescaled tick. The tick comes from the system clock divided by `PRESCALE_DIV`. The default ratio targets a tick near 760 Hz from a 100 MHz clock. Escalation has two stages. On the first expiry the block raises a non-maskable interrupt and reloads a short grace count. If the grace count then runs out with no accepted rewrite, the block issues a one-cycle reset request and halts. An accepted rewrite services the watchdog: it reloads the count, drops the interrupt and re-arms the first stage.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, ctrl_o reads 0, count_o reads 0, nmi_o and rst_req_o are low, and the counter does not move.
- R2: While stored bit 8 of ctrl_o is 0, every write is accepted and ctrl_o takes the written word one cycle later, whatever its key bits [15:9].
- R3: While stored bit 8 of ctrl_o is 1, a write is accepted only if its bits [15:9] equal the bitwise inverse of ctrl_o[15:9]. Otherwise ctrl_o and count_o are left unchanged and the running count keeps stepping as if no write had occurred.
- R4: An accepted write with bit 8 set loads count_o from bits [8:0] and runs. The prescaler restarts on that write, so count_o drops by one every PRESCALE_DIV cycles, with the first step PRESCALE_DIV cycles after the write edge.
- R5: An accepted write with bit 8 clear loads count_o from bits [8:0] and holds it there.
- R6: A count field of 0 loads 256.
- R7: The first expiry is the tick that takes the count from 1. On that tick nmi_o rises, count_o reloads GRACE_TICKS (10 by default) and counting goes on.
- R8: If the count expires again with nmi_o still raised, rst_req_o pulses high for exactly one cycle and the counter stops at 0 with nmi_o still high.
- R9: An accepted write lowers nmi_o on the next cycle and re-arms escalation, so the next expiry raises nmi_o again and does not request reset.
- R10: Once raised, nmi_o stays high until an accepted write or reset, and a rejected write does not lower it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe for the control word |
| wr_data_i | input | 32 | Control word presented with the strobe |
| ctrl_o | output | 32 | Currently stored control word |
| count_o | output | 9 | Remaining ticks before expiry |
| nmi_o | output | 1 | Non-maskable interrupt, first stage |
| rst_req_o | output | 1 | One-cycle system reset request, second stage |

## Verification
The assertions take wr_en_i and wr_data_i to be known, stable values at every rising edge. They also take GRACE_TICKS to be nonzero and to fit the 9-bit counter, so that a first expiry always reloads a count that can later expire. The bench drives its inputs only on falling edges, keeps each write to one cycle, and uses the default grace count with a short prescaler ratio. Under those conditions the acceptance rule the checker derives from the ports matches the one the design applies.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned CNT_FIELD_W = 9;
  localparam int unsigned RUN_BIT     = 8;
  localparam int unsigned KEY_LSB     = 9;
  localparam int unsigned KEY_W       = 7;

  typedef enum logic [1:0] {
    ESC_ARMED,
    ESC_WARNED,
    ESC_FIRED
  } esc_e;
endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
  parameter int unsigned PRESCALE_DIV = 131579
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;

  generate
    if (PRESCALE_DIV <= 1) begin : g_bypass
      logic unused_restart;
      assign unused_restart = restart_i;
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pre_q;
      logic          wrap;
      assign wrap   = (pre_q == PW'(PRESCALE_DIV - 1));
      assign tick_o = wrap;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                pre_q <= '0;
        else if (restart_i || wrap) pre_q <= '0;
        else                        pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/kwd_ctrl_gate.sv
module kwd_ctrl_gate
  import keyed_watchdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              accept_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic [KEY_W-1:0]  key_new, key_need;

  assign key_new  = wr_data_i[KEY_LSB +: KEY_W];
  assign key_need = ~ctrl_q[KEY_LSB +: KEY_W];
  // Once running, only the inverted key may rewrite the word.
  assign accept_o = wr_en_i && (!ctrl_q[RUN_BIT] || (key_new == key_need));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (accept_o) ctrl_q <= wr_data_i;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/kwd_countdown.sv
module kwd_countdown
  import keyed_watchdog_pkg::*;
#(
  parameter int unsigned GRACE_TICKS = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [CNT_FIELD_W-1:0] field_i,
  input  logic                   run_i,
  input  logic                   tick_i,
  output logic [CNT_FIELD_W-1:0] count_o,
  output logic                   nmi_o,
  output logic                   rst_req_o
);
  localparam logic [CNT_FIELD_W-1:0] ZERO_LOAD = CNT_FIELD_W'(1 << (CNT_FIELD_W - 1));
  localparam logic [CNT_FIELD_W-1:0] GRACE     = CNT_FIELD_W'(GRACE_TICKS);

  logic [CNT_FIELD_W-1:0] cnt_q, load_val;
  logic                   run_q, nmi_q, rreq_q;
  esc_e                   esc_q;

  assign load_val = (field_i == '0) ? ZERO_LOAD : field_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      nmi_q  <= 1'b0;
      rreq_q <= 1'b0;
      esc_q  <= ESC_ARMED;
    end else begin
      rreq_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val;
        run_q <= run_i;
        nmi_q <= 1'b0;
        esc_q <= ESC_ARMED;
      end else if (run_q && tick_i) begin
        if (cnt_q <= 1) begin
          if (esc_q == ESC_ARMED) begin
            nmi_q <= 1'b1;
            cnt_q <= GRACE;
            esc_q <= ESC_WARNED;
          end else begin
            rreq_q <= 1'b1;
            run_q  <= 1'b0;
            cnt_q  <= '0;
            esc_q  <= ESC_FIRED;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign count_o   = cnt_q;
  assign nmi_o     = nmi_q;
  assign rst_req_o = rreq_q;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_watchdog_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV = 131579,
  parameter int unsigned GRACE_TICKS  = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic [DATA_W-1:0]      ctrl_o,
  output logic [CNT_FIELD_W-1:0] count_o,
  output logic                   nmi_o,
  output logic                   rst_req_o
);
  logic accept, tick;

  kwd_ctrl_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .ctrl_o   (ctrl_o),
    .accept_o (accept)
  );

  kwd_prescaler #(.PRESCALE_DIV(PRESCALE_DIV)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(accept),
    .tick_o   (tick)
  );

  kwd_countdown #(.GRACE_TICKS(GRACE_TICKS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .field_i  (wr_data_i[CNT_FIELD_W-1:0]),
    .run_i    (wr_data_i[RUN_BIT]),
    .tick_i   (tick),
    .count_o  (count_o),
    .nmi_o    (nmi_o),
    .rst_req_o(rst_req_o)
  );
endmodule

// File: rtl/keyed_watchdog_sva.sv
module keyed_watchdog_sva
  import keyed_watchdog_pkg::*;
#(
  parameter int unsigned GRACE_TICKS = 10
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic [DATA_W-1:0]      wr_data_i,
  input logic [DATA_W-1:0]      ctrl_o,
  input logic [CNT_FIELD_W-1:0] count_o,
  input logic                   nmi_o,
  input logic                   rst_req_o
);
  logic key_ok, good_wr, bad_wr;
  assign key_ok  = (wr_data_i[KEY_LSB +: KEY_W] == ~ctrl_o[KEY_LSB +: KEY_W]);
  assign good_wr = wr_en_i && (!ctrl_o[RUN_BIT] || key_ok);
  assign bad_wr  = wr_en_i && ctrl_o[RUN_BIT] && !key_ok;

  p_open_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !ctrl_o[RUN_BIT]) |=> (ctrl_o == $past(wr_data_i)));

  p_bad_key_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> $stable(ctrl_o));

  p_grace_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) |-> (count_o == CNT_FIELD_W'(GRACE_TICKS)));

  p_rst_req_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  p_rst_after_nmi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (nmi_o && count_o == '0));

  p_service_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_wr |=> !nmi_o);

  p_nmi_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_o && !good_wr) |=> nmi_o);
endmodule

bind keyed_watchdog keyed_watchdog_sva #(.GRACE_TICKS(GRACE_TICKS)) u_sva (.*);

// File: tb/keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
module keyed_watchdog_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] ctrl_o;
  logic [8:0]  count_o;
  logic        nmi_o, rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  keyed_watchdog #(.PRESCALE_DIV(4), .GRACE_TICKS(10)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .ctrl_o(ctrl_o), .count_o(count_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // Called on a falling edge; returns one cycle after the capture edge.
  task automatic wr(logic [31:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    wait_cyc(2);
    rst_ni = 1'b1;
    wait_cyc(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ctrl", ctrl_o, 32'h0);
    chk("R1 count", {23'd0, count_o}, 32'd0);
    chk("R1 nmi", {31'd0, nmi_o}, 32'd0);
    chk("R1 rst_req", {31'd0, rst_req_o}, 32'd0);
    wait_cyc(20);
    chk("R1 idle count", {23'd0, count_o}, 32'd0);
  endtask

  task automatic t_open_writes();
    do_reset();
    wr(32'h0000_0005);
    chk("R2 ctrl", ctrl_o, 32'h0000_0005);
    chk("R5 load", {23'd0, count_o}, 32'd5);
    wait_cyc(20);
    chk("R5 hold", {23'd0, count_o}, 32'd5);
    wr(32'hABCD_0000);
    chk("R2 any key", ctrl_o, 32'hABCD_0000);
    chk("R6 zero as 256", {23'd0, count_o}, 32'd256);
  endtask

  task automatic t_run_and_keys();
    do_reset();
    wr(32'h0000_2B03);                       // key 0x15, run, 259
    chk("R4 load", {23'd0, count_o}, 32'd259);
    wait_cyc(3);
    chk("R4 before tick", {23'd0, count_o}, 32'd259);
    wait_cyc(1);
    chk("R4 first step", {23'd0, count_o}, 32'd258);
    wr(32'h0000_2B50);                       // same key: rejected
    chk("R3 ctrl kept", ctrl_o, 32'h0000_2B03);
    chk("R3 count kept", {23'd0, count_o}, 32'd258);
    wait_cyc(3);
    chk("R3 still counting", {23'd0, count_o}, 32'd257);
    wr(32'h0000_D502);                       // key 0x6A = ~0x15
    chk("R3 good key", ctrl_o, 32'h0000_D502);
    chk("R3 reload", {23'd0, count_o}, 32'd258);
    wr(32'h0000_2A07);                       // key 0x15, stop, 7
    chk("R5 stop ctrl", ctrl_o, 32'h0000_2A07);
    wait_cyc(10);
    chk("R5 stopped", {23'd0, count_o}, 32'd7);
  endtask

  task automatic t_escalate();
    do_reset();
    wr(32'h0000_2301);                       // key 0x11, run, 257
    wait_cyc(1027);
    chk("R7 before expiry", {31'd0, nmi_o}, 32'd0);
    chk("R7 last count", {23'd0, count_o}, 32'd1);
    wait_cyc(1);
    chk("R7 nmi", {31'd0, nmi_o}, 32'd1);
    chk("R7 grace", {23'd0, count_o}, 32'd10);
    wr(32'h0000_2301);                       // wrong key
    chk("R10 nmi held", {31'd0, nmi_o}, 32'd1);
    chk("R10 ctrl kept", ctrl_o, 32'h0000_2301);
    wait_cyc(38);
    chk("R8 no early req", {31'd0, rst_req_o}, 32'd0);
    wait_cyc(1);
    chk("R8 req", {31'd0, rst_req_o}, 32'd1);
    chk("R8 nmi high", {31'd0, nmi_o}, 32'd1);
    chk("R8 count 0", {23'd0, count_o}, 32'd0);
    wait_cyc(1);
    chk("R8 one cycle", {31'd0, rst_req_o}, 32'd0);
    wait_cyc(20);
    chk("R8 halted", {23'd0, count_o}, 32'd0);
    chk("R8 no repeat", {31'd0, rst_req_o}, 32'd0);
  endtask

  task automatic t_service();
    do_reset();
    wr(32'h0000_2301);
    wait_cyc(1028);
    chk("R9 nmi up", {31'd0, nmi_o}, 32'd1);
    wr(32'h0000_DD04);                       // key 0x6E, run, 260
    chk("R9 nmi cleared", {31'd0, nmi_o}, 32'd0);
    chk("R9 reload", {23'd0, count_o}, 32'd260);
    wait_cyc(1039);
    chk("R9 quiet", {31'd0, nmi_o}, 32'd0);
    wait_cyc(1);
    chk("R9 first stage again", {31'd0, nmi_o}, 32'd1);
    chk("R9 no reset req", {31'd0, rst_req_o}, 32'd0);
    chk("R9 grace", {23'd0, count_o}, 32'd10);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_open_writes();
    t_run_and_keys();
    t_escalate();
    t_service();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule